// File: doc/BRIEF.md
# Dual-Role Serial Port with Word Request Handshake

This block is a serial port that works either as the clocking master or as a clocked slave on a four-wire SPI bus. An extra active-low request line paces every word in both roles. The word length is a parameter, 24 bits by default. Data moves most significant bit first in SPI mode 0: the clock idles low, bits are sampled on the rising edge, and the data line changes after the falling edge. A parallel side loads the next word to send and returns each received word with a one-cycle done pulse.

As slave, the port drives the request line low once a word has been loaded, which tells the external master that the port is ready. It releases the line at the first rising clock edge of the next word. It answers only while slave-select is low, and its serial inputs pass through synchronizers first. As master, it generates the serial clock from the system clock through a programmable divider. It clocks one word only after the external slave pulls the request low. After each word it waits for the request to be released and asserted again. Slave-select seen low while the port is master sets a sticky bus error flag, and a write-one-to-clear control input resets that flag.

Top module: `spq_port`

## Requirements
- R1: After reset, sck_o is low, sck_oe, mosi_oe, miso_oe and hreq_oe are low, bus_err is low and done is low.
- R2: In master mode each SCK half period lasts cfg_div+1 clock cycles, so one full SCK period is 2*(cfg_div+1) cycles, and SCK rests low between words.
- R3: In master mode a word goes out on mosi_o most significant bit first, and miso_i is sampled at each SCK rising edge. After the last falling edge, done pulses high for exactly one cycle and rx_word holds the received word.
- R4: In master mode no SCK edge is produced unless a word has been loaded and the synchronized hreq_n_i is low.
- R5: After a word completes in master mode, the next word does not start until hreq_n_i has been seen high and then low again, even if a new word is already loaded.
- R6: While the port is enabled as master, slave-select (ss_n_i) seen low sets bus_err. bus_err then stays set until err_clr is pulsed, and a set condition takes priority over a clear in the same cycle.
- R7: In slave mode mosi_i is sampled at each SCK rising edge and miso_o carries the loaded word most significant bit first. The received word appears on rx_word with a one-cycle done pulse after the word's last falling edge.
- R8: In slave mode, while ss_n_i is high, SCK edges are ignored (no bit is counted and the ready state is kept) and miso_oe is low.
- R9: In slave mode hreq_n_o goes low after a word is loaded and goes high at the first SCK rising edge of the next word. It stays high until the next word is loaded.
- R10: hreq_oe is high only in slave mode with at least one of the two bits of cfg_req_en set. With cfg_req_en equal to 2'b00 it is low.
- R11: sck_oe and mosi_oe are high only when the port is enabled as master. miso_oe is never high together with mosi_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 selects master role, 0 selects slave role |
| cfg_req_en | input | 2 | Request driver enable bits; both clear tristates the request output |
| cfg_div | input | DIV_W | Master SCK half-period divider (half period = cfg_div+1 cycles) |
| err_clr | input | 1 | Write-one-to-clear pulse for bus_err |
| tx_load | input | 1 | Load tx_word as the next word (ignored mid-word) |
| tx_word | input | W | Word to send |
| rx_word | output | W | Last received word |
| done | output | 1 | One-cycle pulse when a word completes |
| bus_err | output | 1 | Sticky bus error flag |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Active-low slave-select |
| hreq_n_o | output | 1 | Active-low ready request driven as slave |
| hreq_oe | output | 1 | Request output enable |
| hreq_n_i | input | 1 | Active-low request received as master |

## Verification
The bench holds a loaded master word while the request is high, and then holds a second loaded word while the request stays low after the first word. A master that did not wait for a request, or did not re-arm after a word, would produce SCK edges in those windows. It pulses SCK while slave-select is high and then runs a full slave word. A port that counted those stray edges would finish the word early, return a shifted word or raise an unexpected done. It also checks that the request rises at the first rising edge and stays high after the word, and that the bus error survives slave-select going high until the clear pulse. A flag that was not sticky, or an early request release, would show at those samples.

// File: rtl/spq_pkg.sv
package spq_pkg;

  typedef enum logic [0:0] {
    M_IDLE = 1'b0,
    M_RUN  = 1'b1
  } mst_state_e;

  typedef struct packed {
    logic sck;
    logic ss_n;
    logic hreq_n;
    logic mosi;
  } pin_sync_t;

  localparam int unsigned PIN_W = $bits(pin_sync_t);

  localparam pin_sync_t PIN_RST = '{sck: 1'b0, ss_n: 1'b1, hreq_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spq_sync.sv
module spq_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spq_sckgen.sv
module spq_sckgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tick;

  assign tick = run && (cnt_q >= div);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = tick && !sck_q;
  assign fall = tick && sck_q;

endmodule

// File: rtl/spq_shifter.sv
module spq_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         clear,
  input  logic         rise,
  input  logic         fall,
  input  logic         din,
  output logic         dout,
  output logic         first,
  output logic         last,
  output logic         mid,
  output logic         done,
  output logic [W-1:0] rx_word
);

  localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bit_q, bit_d;
  logic             phase_q, phase_d;
  logic             done_q, done_d;

  always_comb begin
    sh_d    = sh_q;
    rx_d    = rx_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    if (load) begin
      sh_d    = load_word;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (clear) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (rise) begin
      bit_d   = din;
      phase_d = 1'b1;
    end else if (fall && phase_q) begin
      sh_d    = {sh_q[W-2:0], bit_q};
      phase_d = 1'b0;
      if (cnt_q == LAST_BIT) begin
        cnt_d  = '0;
        done_d = 1'b1;
        rx_d   = {sh_q[W-2:0], bit_q};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      bit_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign dout    = sh_q[W-1];
  assign first   = (cnt_q == '0) && !phase_q;
  assign last    = (cnt_q == LAST_BIT) && phase_q;
  assign mid     = !first;
  assign done    = done_q;
  assign rx_word = rx_q;

endmodule

// File: rtl/spq_port.sv
module spq_port
  import spq_pkg::*;
#(
  parameter int unsigned W           = 24,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_req_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             err_clr,
  input  logic             tx_load,
  input  logic [W-1:0]     tx_word,
  output logic [W-1:0]     rx_word,
  output logic             done,
  output logic             bus_err,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             sck_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i,
  input  logic             ss_n_i,
  output logic             hreq_n_o,
  output logic             hreq_oe,
  input  logic             hreq_n_i
);

  // pin synchronizers
  pin_sync_t        pins_raw, pins_s;
  logic [PIN_W-1:0] pins_q;

  assign pins_raw.sck    = sck_i;
  assign pins_raw.ss_n   = ss_n_i;
  assign pins_raw.hreq_n = hreq_n_i;
  assign pins_raw.mosi   = mosi_i;

  spq_sync #(.N(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_q)
  );
  assign pins_s = pin_sync_t'(pins_q);

  logic ss_s, hreq_s;
  assign ss_s   = pins_s.ss_n;
  assign hreq_s = pins_s.hreq_n;

  // role decode and slave edge detection
  logic is_mst, is_slv, slv_sel;
  logic sck_prev_q;
  logic s_rise, s_fall;

  assign is_mst  = cfg_en && cfg_master;
  assign is_slv  = cfg_en && !cfg_master;
  assign slv_sel = is_slv && !ss_s;
  assign s_rise  = slv_sel && pins_s.sck && !sck_prev_q;
  assign s_fall  = slv_sel && !pins_s.sck && sck_prev_q;

  // master clock generator
  mst_state_e mst_q, mst_d;
  logic       running;
  logic       m_sck, m_rise, m_fall;

  assign running = (mst_q == M_RUN);

  spq_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .div  (cfg_div),
    .sck  (m_sck),
    .rise (m_rise),
    .fall (m_fall)
  );

  // shared shifter
  logic sh_dout, sh_first, sh_last, sh_mid;
  logic sh_rise, sh_fall, sh_din, sh_clear;
  logic load_ok, start;

  assign sh_rise  = is_mst ? m_rise : s_rise;
  assign sh_fall  = is_mst ? m_fall : s_fall;
  assign sh_din   = is_mst ? miso_i : pins_s.mosi;
  assign sh_clear = !cfg_en || (is_slv && ss_s);

  spq_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .load_word(tx_word),
    .clear    (sh_clear),
    .rise     (sh_rise),
    .fall     (sh_fall),
    .din      (sh_din),
    .dout     (sh_dout),
    .first    (sh_first),
    .last     (sh_last),
    .mid      (sh_mid),
    .done     (done),
    .rx_word  (rx_word)
  );

  // control state
  logic full_q, full_d;
  logic armed_q, armed_d;
  logic err_q, err_d;

  assign start   = is_mst && !running && full_q && armed_q && !hreq_s;
  assign load_ok = tx_load && !running && !sh_mid && !start;

  always_comb begin
    mst_d = mst_q;
    if (!is_mst) begin
      mst_d = M_IDLE;
    end else if (start) begin
      mst_d = M_RUN;
    end else if (running && m_fall && sh_last) begin
      mst_d = M_IDLE;
    end

    full_d = full_q;
    if (start) begin
      full_d = 1'b0;
    end else if (load_ok) begin
      full_d = 1'b1;
    end else if (s_rise && sh_first) begin
      full_d = 1'b0;
    end

    armed_d = armed_q;
    if (start) begin
      armed_d = 1'b0;
    end else if (hreq_s) begin
      armed_d = 1'b1;
    end

    err_d = err_q;
    if (is_mst && !ss_s) begin
      err_d = 1'b1;
    end else if (err_clr) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q      <= M_IDLE;
      full_q     <= 1'b0;
      armed_q    <= 1'b0;
      err_q      <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      mst_q      <= mst_d;
      full_q     <= full_d;
      armed_q    <= armed_d;
      err_q      <= err_d;
      sck_prev_q <= pins_s.sck;
    end
  end

  // pin drivers
  assign sck_o    = m_sck;
  assign sck_oe   = is_mst;
  assign mosi_o   = sh_dout;
  assign mosi_oe  = is_mst;
  assign miso_o   = sh_dout;
  assign miso_oe  = slv_sel;
  assign hreq_n_o = ~full_q;
  assign hreq_oe  = is_slv && (|cfg_req_en);
  assign bus_err  = err_q;

endmodule

// File: rtl/spq_port_chk.sv
module spq_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_master,
  input logic err_clr,
  input logic tx_load,
  input logic ss_s,
  input logic hreq_s,
  input logic running,
  input logic s_rise,
  input logic sh_first,
  input logic done,
  input logic bus_err,
  input logic sck_o,
  input logic miso_oe,
  input logic mosi_oe,
  input logic hreq_n_o
);

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_master && !ss_s) |=> bus_err);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !err_clr) |=> bus_err);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !sck_o);

  p_wait_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !running && hreq_s) |=> !running);

  p_hreq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rise && sh_first && !tx_load) |=> hreq_n_o);

  p_oe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && mosi_oe));

endmodule

bind spq_port spq_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_master(cfg_master),
  .err_clr   (err_clr),
  .tx_load   (tx_load),
  .ss_s      (ss_s),
  .hreq_s    (hreq_s),
  .running   (running),
  .s_rise    (s_rise),
  .sh_first  (sh_first),
  .done      (done),
  .bus_err   (bus_err),
  .sck_o     (sck_o),
  .miso_oe   (miso_oe),
  .mosi_oe   (mosi_oe),
  .hreq_n_o  (hreq_n_o)
);

// File: tb/tb_spq_port.sv
`timescale 1ns/1ps
module tb_spq_port;

  localparam int unsigned W     = 24;
  localparam int unsigned DIV_W = 8;
  localparam int          HALF  = 8;

  logic             clk;
  logic             rst_n;
  logic             cfg_en, cfg_master, err_clr, tx_load;
  logic [1:0]       cfg_req_en;
  logic [DIV_W-1:0] cfg_div;
  logic [W-1:0]     tx_word, rx_word;
  logic             done, bus_err;
  logic             sck_o, sck_oe, sck_i;
  logic             mosi_o, mosi_oe, mosi_i;
  logic             miso_o, miso_oe, miso_i;
  logic             ss_n_i, hreq_n_o, hreq_oe, hreq_n_i;

  int checks;
  int errors;

  spq_port #(.W(W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_req_en(cfg_req_en), .cfg_div(cfg_div), .err_clr(err_clr),
    .tx_load(tx_load), .tx_word(tx_word), .rx_word(rx_word), .done(done),
    .bus_err(bus_err), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i), .hreq_n_o(hreq_n_o),
    .hreq_oe(hreq_oe), .hreq_n_i(hreq_n_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // external slave model for master-role tests
  logic [W-1:0] ext_tx, ext_rx;
  int           sck_edges;
  assign miso_i = ext_tx[W-1];

  always @(posedge sck_o) begin
    ext_rx    <= {ext_rx[W-2:0], mosi_o};
    sck_edges <= sck_edges + 1;
  end
  always @(negedge sck_o) ext_tx <= {ext_tx[W-2:0], 1'b0};

  // scoreboard
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input string tag, input logic [W-1:0] w);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        chk(tag_q.pop_front(), rx_word, exp_q.pop_front());
      end
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    tx_word = w;
    tx_load = 1'b1;
    wait_clks(1);
    tx_load = 1'b0;
  endtask

  // external master model for slave-role tests
  task automatic slv_xfer(input logic [W-1:0] mword, output logic [W-1:0] got);
    ss_n_i = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < W; i++) begin
      mosi_i = mword[W-1-i];
      wait_clks(HALF);
      got[W-1-i] = miso_o;
      sck_i = 1'b1;
      if (i == 0) begin
        wait_clks(5);
        chk("R9 request released at first rise", W'(hreq_n_o), W'(1));
        wait_clks(HALF - 5);
      end else begin
        wait_clks(HALF);
      end
      sck_i = 1'b0;
    end
    wait_clks(HALF);
    ss_n_i = 1'b1;
    wait_clks(4);
  endtask

  initial begin
    automatic realtime t1;
    automatic realtime t2;
    automatic logic [W-1:0] got;
    automatic int edges0;
    checks = 0; errors = 0; sck_edges = 0;
    ext_tx = '0; ext_rx = '0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_master = 1'b1; cfg_req_en = 2'b01;
    cfg_div = 8'd1; err_clr = 1'b0; tx_load = 1'b0; tx_word = '0;
    sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1; hreq_n_i = 1'b1;
    wait_clks(4);
    // R1 reset state
    chk("R1 outputs enables", W'({sck_o, sck_oe, mosi_oe, miso_oe, hreq_oe}), W'(0));
    chk("R1 bus_err and done", W'({bus_err, done}), W'(0));
    rst_n = 1'b1;
    wait_clks(2);

    // ---------------- master role ----------------
    cfg_en = 1'b1;
    wait_clks(4);
    chk("R11 master drives sck and mosi", W'({sck_oe, mosi_oe, miso_oe}), W'(3'b110));
    load_word(24'hA5C3_0F);
    wait_clks(100);
    chk("R4 no sck while request high", W'(sck_edges), W'(0));
    ext_tx = 24'h3C_5A96;
    push_exp("R3 master receive", 24'h3C_5A96);
    hreq_n_i = 1'b0;
    wait_clks(150);
    chk("R3 slave captured master word", ext_rx, 24'hA5C3_0F);
    chk("R2 sck rests low after word", W'(sck_o), W'(0));

    // R5: request still low, new word loaded: must not start
    edges0 = sck_edges;
    cfg_div = 8'd3;
    ext_tx = 24'hF0_0F81;
    load_word(24'h12_3456);
    wait_clks(100);
    chk("R5 no restart without new request", W'(sck_edges), W'(edges0));
    push_exp("R3 master receive second", 24'hF0_0F81);
    hreq_n_i = 1'b1;
    wait_clks(4);
    hreq_n_i = 1'b0;
    @(posedge sck_o); t1 = $realtime;
    @(posedge sck_o); t2 = $realtime;
    chk("R2 sck period at div 3", W'(int'((t2 - t1) / 5.0)), W'(8));
    wait_clks(230);
    chk("R3 slave captured second word", ext_rx, 24'h12_3456);
    chk("R4 one word per request", W'(sck_edges - edges0), W'(W));

    // R6 bus error
    chk("R6 no error before select", W'(bus_err), W'(0));
    ss_n_i = 1'b0;
    wait_clks(5);
    chk("R6 error set by select low", W'(bus_err), W'(1));
    ss_n_i = 1'b1;
    wait_clks(5);
    chk("R6 error sticky", W'(bus_err), W'(1));
    err_clr = 1'b1;
    wait_clks(1);
    err_clr = 1'b0;
    wait_clks(2);
    chk("R6 error cleared", W'(bus_err), W'(0));

    // ---------------- slave role ----------------
    cfg_master = 1'b0;
    hreq_n_i = 1'b1;
    wait_clks(4);
    chk("R11 slave drives neither sck nor mosi", W'({sck_oe, mosi_oe}), W'(0));
    chk("R9 request high with nothing loaded", W'(hreq_n_o), W'(1));
    chk("R10 request driver enabled", W'(hreq_oe), W'(1));
    load_word(24'hC0_FFEE);
    wait_clks(2);
    chk("R9 request low after load", W'(hreq_n_o), W'(0));

    // R8 stray clocks while deselected
    for (int k = 0; k < 10; k++) begin
      sck_i = 1'b1; wait_clks(HALF);
      sck_i = 1'b0; wait_clks(HALF);
    end
    chk("R8 miso off while deselected", W'(miso_oe), W'(0));
    chk("R8 ready kept while deselected", W'(hreq_n_o), W'(0));

    push_exp("R7 slave receive", 24'h69_1E2D);
    slv_xfer(24'h69_1E2D, got);
    chk("R7 slave sent loaded word", got, 24'hC0_FFEE);
    chk("R9 request stays high after word", W'(hreq_n_o), W'(1));
    chk("R8 miso off after deselect", W'(miso_oe), W'(0));

    load_word(24'h80_0001);
    wait_clks(2);
    push_exp("R7 slave receive second", 24'h00_0001);
    slv_xfer(24'h00_0001, got);
    chk("R7 slave sent second word", got, 24'h80_0001);

    // R10 request driver enable
    cfg_req_en = 2'b00;
    wait_clks(1);
    chk("R10 driver off with both bits clear", W'(hreq_oe), W'(0));
    cfg_req_en = 2'b10;
    wait_clks(1);
    chk("R10 driver on with upper bit", W'(hreq_oe), W'(1));

    wait_clks(10);
    chk("R3 R7 all expected words seen", W'(exp_q.size()), W'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule